// File: doc/BRIEF.md
# Multi-Context Translation Register Bank

This block is the software-visible register file for a small I/O address translation unit that serves several independent translation contexts. A 32-bit register bus with one-cycle read latency reaches every context. Each context holds a control word, a translation-control word, a bus-control word, a two-word page-table base, a memory-attribute word, a fault status word and a two-word fault address. The page-table walker and the TLB sit outside the block. They connect through a per-context flush request and flush done pair, and through one shared fault-report port.

Contexts 0 to 7 each take a 64-byte slot starting at address 0. Contexts 8 and above are moved to a second window that begins at 0x800. Each context runs a small flush state machine with two states. FL_IDLE moves to FL_BUSY on the transition *flush start*, which is a control write with the flush bit set. FL_BUSY returns to FL_IDLE on one of two transitions: *flush done*, when the done input arrives, or *watchdog expiry*, when the done input has not arrived after `FLUSH_TIMEOUT` busy cycles.

Faults are recorded on a first-come basis. The status flags and the 64-bit address of the first fault are held until software writes zero to the status word. That write also erases the fault address. A single interrupt line combines the pending faults of every context whose interrupt enable is set.

Top module: `xlat_ctx_regbank`

## Requirements
- R1: After reset, every register of every context reads zero, and `irq`, `flush_req` and `flush_timeout` are low.
- R2: Context n (n < 8) occupies base n*0x40, and context n (n ≥ 8) occupies base 0x800+(n-8)*0x40. Within a context, the offsets are: 0x00 control, 0x08 translation control, 0x0C bus control, 0x10 table base low, 0x14 table base high, 0x20 status, 0x28 attributes, 0x30 fault address low, 0x34 fault address high. The five configuration words (0x08, 0x0C, 0x10, 0x14, 0x28) are fully read/write. Read data appears on `reg_rdata` one clock after the cycle in which `reg_rd` is sampled.
- R3: A read of any unmapped address returns zero, and a write to it changes nothing. Unmapped addresses include offsets not listed in R2, 0x200–0x7FF, and the space above the last context. Writes to the fault address words are ignored.
- R4: In the control word, bit 2 is interrupt enable and bit 0 is translation enable. Both read back as written, and all bits above 2 read zero. Writing 0 disables the context.
- R5: A control write with bit 1 set, made while the context is in FL_IDLE, raises that context's `flush_req` bit for exactly one cycle. Bit 1 of the control word then reads 1 for as long as the context is in FL_BUSY.
- R6: In FL_BUSY, a `flush_done` pulse returns the context to FL_IDLE on that clock edge. If done does not arrive, the context returns to FL_IDLE after `FLUSH_TIMEOUT` cycles and sets its `flush_timeout` bit. That bit stays set until the next flush start.
- R7: A fault report (`fault_valid`, `fault_ctx`, `fault_flags`, `fault_addr`) stores the flags into status, keeping only bit 4 multiple hit, bit 2 walk abort, bit 1 page fault and bit 0 translation fault. It stores the address into the low and high fault address words. A report whose kept flags are all zero is ignored.
- R8: While a context's status is nonzero, later fault reports to that context leave its status and fault address unchanged.
- R9: Writing zero to status clears the status and both fault address words. A nonzero write to status has no effect.
- R10: `irq` is high exactly when some context has interrupt enable set and a nonzero status.
- R11: A flush write to a context already in FL_BUSY produces no new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read strobe |
| fault_valid | input | 1 | Fault report strobe from the walker |
| fault_ctx | input | CTX_W | Context the fault belongs to |
| fault_flags | input | 5 | Raw fault flags |
| fault_addr | input | 64 | Faulting input address |
| flush_req | output | NUM_CTX | One-cycle flush request per context |
| flush_done | input | NUM_CTX | Flush completion per context |
| flush_timeout | output | NUM_CTX | Sticky watchdog-expiry flag per context |
| irq | output | 1 | Combined fault interrupt |

## Verification
Suppose a context is stuck in FL_BUSY, or was never started. The fault is visible on the port the next time control bit 1 is read. A missing or doubled `flush_req` pulse can be seen on the clock edge after the control write. A wrong watchdog count moves the rise of `flush_timeout` away from the exact cycle `FLUSH_TIMEOUT` after the start. Suppose the decoder folds the relocated window onto 0x200. Then a write there corrupts context 8, and the next readback of context 8 shows it. Corrupted fault latching shows on `irq` within one cycle of the report. It also shows in the status or address words read afterwards, even before the status is cleared.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam logic [5:0] OFF_CTRL = 6'h00;
    localparam logic [5:0] OFF_TTBC = 6'h08;
    localparam logic [5:0] OFF_BUSC = 6'h0C;
    localparam logic [5:0] OFF_TLO  = 6'h10;
    localparam logic [5:0] OFF_THI  = 6'h14;
    localparam logic [5:0] OFF_STAT = 6'h20;
    localparam logic [5:0] OFF_ATTR = 6'h28;
    localparam logic [5:0] OFF_ELO  = 6'h30;
    localparam logic [5:0] OFF_EHI  = 6'h34;

    localparam int CTRL_IE_BIT = 2;
    localparam int CTRL_FL_BIT = 1;
    localparam int CTRL_EN_BIT = 0;

    // multiple hit, walk abort, page fault, translation fault
    localparam logic [4:0] STAT_KEEP = 5'b10111;

    // slot index (address / 0x40) where the relocated window starts
    localparam int HI_SLOT_BASE = 32;

    typedef enum logic {
        FL_IDLE = 1'b0,
        FL_BUSY = 1'b1
    } flush_state_e;
endpackage

// File: rtl/xlat_addr_dec.sv
module xlat_addr_dec
    import xlat_pkg::*;
#(
    parameter int NUM_CTX = 16,
    parameter int ADDR_W  = 12,
    localparam int CTX_W  = $clog2(NUM_CTX)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [CTX_W-1:0]  ctx,
    output logic [5:0]        off
);
    localparam int SLOT_W = ADDR_W - 6;
    localparam int LO_CNT = (NUM_CTX < 8) ? NUM_CTX : 8;
    localparam int HI_CNT = (NUM_CTX > 8) ? NUM_CTX - 8 : 0;

    logic [SLOT_W-1:0] slot;

    always_comb begin
        slot = addr[ADDR_W-1:6];
        off  = addr[5:0];
        hit  = 1'b0;
        ctx  = '0;
        if (slot < SLOT_W'(LO_CNT)) begin
            hit = 1'b1;
            ctx = CTX_W'(slot);
        end else if ((HI_CNT > 0) && (slot >= SLOT_W'(HI_SLOT_BASE)) &&
                     (slot < SLOT_W'(HI_SLOT_BASE + HI_CNT))) begin
            hit = 1'b1;
            ctx = CTX_W'(slot - SLOT_W'(HI_SLOT_BASE - 8));
        end
    end
endmodule

// File: rtl/xlat_ctx_unit.sv
module xlat_ctx_unit
    import xlat_pkg::*;
#(
    parameter int FLUSH_TIMEOUT = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [5:0]  off,
    input  logic [31:0] wdata,
    input  logic        flt_en,
    input  logic [4:0]  flt_flags,
    input  logic [63:0] flt_addr,
    input  logic        flush_done,
    output logic [31:0] rd_val,
    output logic        flush_req,
    output logic        flush_to,
    output logic        irq
);
    localparam int WD_W = $clog2(FLUSH_TIMEOUT + 1);
    localparam logic [WD_W-1:0] WD_LIMIT = WD_W'(FLUSH_TIMEOUT - 1);

    flush_state_e state_q, state_d;
    logic [WD_W-1:0] wdog_q;
    logic        ie_q, en_q;
    logic [31:0] ttbc_q, busc_q, tlo_q, thi_q, attr_q, elo_q, ehi_q;
    logic [4:0]  stat_q, flt_kept;
    logic        wr_ctrl, flush_start, stat_clr, flt_take, wd_expire;

    assign wr_ctrl     = wr_en && (off == OFF_CTRL);
    assign flush_start = wr_ctrl && wdata[CTRL_FL_BIT];
    assign stat_clr    = wr_en && (off == OFF_STAT) && (wdata == 32'd0);
    assign flt_kept    = flt_flags & STAT_KEEP;
    assign flt_take    = flt_en && (flt_kept != 5'd0) && ((stat_q == 5'd0) || stat_clr);
    assign wd_expire   = (state_q == FL_BUSY) && !flush_done && (wdog_q == WD_LIMIT);
    assign irq         = ie_q && (stat_q != 5'd0);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE: if (flush_start) state_d = FL_BUSY;
            FL_BUSY: if (flush_done || wdog_q == WD_LIMIT) state_d = FL_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FL_IDLE;
        else        state_q <= state_d;
    end

    // outputs, watchdog and registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_req <= 1'b0;
            flush_to  <= 1'b0;
            wdog_q    <= '0;
            ie_q      <= 1'b0;
            en_q      <= 1'b0;
            ttbc_q    <= '0;
            busc_q    <= '0;
            tlo_q     <= '0;
            thi_q     <= '0;
            attr_q    <= '0;
            stat_q    <= '0;
            elo_q     <= '0;
            ehi_q     <= '0;
        end else begin
            flush_req <= (state_q == FL_IDLE) && flush_start;
            wdog_q    <= (state_q == FL_BUSY) ? wdog_q + 1'b1 : '0;
            if ((state_q == FL_IDLE) && flush_start) flush_to <= 1'b0;
            else if (wd_expire)                      flush_to <= 1'b1;
            if (wr_ctrl) begin
                ie_q <= wdata[CTRL_IE_BIT];
                en_q <= wdata[CTRL_EN_BIT];
            end
            if (wr_en && off == OFF_TTBC) ttbc_q <= wdata;
            if (wr_en && off == OFF_BUSC) busc_q <= wdata;
            if (wr_en && off == OFF_TLO)  tlo_q  <= wdata;
            if (wr_en && off == OFF_THI)  thi_q  <= wdata;
            if (wr_en && off == OFF_ATTR) attr_q <= wdata;
            if (flt_take) begin
                stat_q <= flt_kept;
                elo_q  <= flt_addr[31:0];
                ehi_q  <= flt_addr[63:32];
            end else if (stat_clr) begin
                stat_q <= '0;
                elo_q  <= '0;
                ehi_q  <= '0;
            end
        end
    end

    always_comb begin
        case (off)
            OFF_CTRL: rd_val = {29'd0, ie_q, (state_q == FL_BUSY), en_q};
            OFF_TTBC: rd_val = ttbc_q;
            OFF_BUSC: rd_val = busc_q;
            OFF_TLO:  rd_val = tlo_q;
            OFF_THI:  rd_val = thi_q;
            OFF_STAT: rd_val = {27'd0, stat_q};
            OFF_ATTR: rd_val = attr_q;
            OFF_ELO:  rd_val = elo_q;
            OFF_EHI:  rd_val = ehi_q;
            default:  rd_val = 32'd0;
        endcase
    end

    assert_req_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> !flush_req);
    assert_req_enters_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> (state_q == FL_BUSY));
    assert_timeout_from_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_to) |-> ($past(state_q) == FL_BUSY));
    assert_first_fault_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q != 5'd0 && !stat_clr) |=> ($stable(stat_q) && $stable(elo_q) && $stable(ehi_q)));
    assert_clear_zeroes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !flt_en) |=> (stat_q == 5'd0 && elo_q == 32'd0 && ehi_q == 32'd0));
    assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ie_q);
endmodule

// File: rtl/xlat_ctx_regbank.sv
module xlat_ctx_regbank
    import xlat_pkg::*;
#(
    parameter int NUM_CTX       = 16,
    parameter int ADDR_W        = 12,
    parameter int FLUSH_TIMEOUT = 32,
    localparam int CTX_W        = $clog2(NUM_CTX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               fault_valid,
    input  logic [CTX_W-1:0]   fault_ctx,
    input  logic [4:0]         fault_flags,
    input  logic [63:0]        fault_addr,
    output logic [NUM_CTX-1:0] flush_req,
    input  logic [NUM_CTX-1:0] flush_done,
    output logic [NUM_CTX-1:0] flush_timeout,
    output logic               irq
);
    logic             dec_hit;
    logic [CTX_W-1:0] dec_ctx;
    logic [5:0]       dec_off;
    logic [31:0]      rd_vals [NUM_CTX];
    logic [NUM_CTX-1:0] irq_vec;

    xlat_addr_dec #(.NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W)) u_dec (
        .addr (reg_addr),
        .hit  (dec_hit),
        .ctx  (dec_ctx),
        .off  (dec_off)
    );

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
        xlat_ctx_unit #(.FLUSH_TIMEOUT(FLUSH_TIMEOUT)) u_ctx (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (reg_wr && dec_hit && (dec_ctx == CTX_W'(i))),
            .off        (dec_off),
            .wdata      (reg_wdata),
            .flt_en     (fault_valid && (fault_ctx == CTX_W'(i))),
            .flt_flags  (fault_flags),
            .flt_addr   (fault_addr),
            .flush_done (flush_done[i]),
            .rd_val     (rd_vals[i]),
            .flush_req  (flush_req[i]),
            .flush_to   (flush_timeout[i]),
            .irq        (irq_vec[i])
        );
    end

    assign irq = |irq_vec;

    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= 32'd0;
        else if (reg_rd) reg_rdata <= dec_hit ? rd_vals[dec_ctx] : 32'd0;
    end

    assert_one_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flush_req));
    assert_unmapped_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !dec_hit) |=> (reg_rdata == 32'd0));
endmodule

// File: tb/tb_xlat_ctx_regbank.sv
module tb_xlat_ctx_regbank;
    localparam int NC = 16;
    localparam int TO = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fault_valid = 1'b0;
    logic [3:0]  fault_ctx = '0;
    logic [4:0]  fault_flags = '0;
    logic [63:0] fault_addr = '0;
    logic [NC-1:0] flush_req, flush_timeout;
    logic [NC-1:0] flush_done = '0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    logic [31:0] m_regs [NC][5];

    always #5 clk = ~clk;

    xlat_ctx_regbank #(.NUM_CTX(NC), .ADDR_W(12), .FLUSH_TIMEOUT(TO)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fault_valid(fault_valid), .fault_ctx(fault_ctx), .fault_flags(fault_flags),
        .fault_addr(fault_addr), .flush_req(flush_req), .flush_done(flush_done),
        .flush_timeout(flush_timeout), .irq(irq)
    );

    function automatic logic [11:0] addr_of(int c, int off);
        if (c < 8) return 12'(c * 64 + off);
        return 12'(32'h800 + (c - 8) * 64 + off);
    endfunction

    function automatic int cfg_off(int k);
        case (k)
            0: return 'h08;
            1: return 'h0C;
            2: return 'h10;
            3: return 'h14;
            default: return 'h28;
        endcase
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(logic [11:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic fault(int c, logic [4:0] f, logic [63:0] a);
        fault_valid = 1'b1; fault_ctx = 4'(c); fault_flags = f; fault_addr = a;
        @(negedge clk);
        fault_valid = 1'b0;
    endtask

    task automatic done_pulse(int c);
        flush_done[c] = 1'b1;
        @(negedge clk);
        flush_done[c] = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd2024));
        for (int c = 0; c < NC; c++)
            for (int k = 0; k < 5; k++) m_regs[c][k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", irq, 0);
        check("R1 flush_req", flush_req, 0);
        check("R1 flush_timeout", flush_timeout, 0);
        rd(addr_of(0, 'h00), d);  check("R1 ctrl0", d, 0);
        rd(addr_of(15, 'h20), d); check("R1 stat15", d, 0);
        rd(addr_of(9, 'h08), d);  check("R1 ttbc9", d, 0);

        // R2 decode across the relocated window
        wr(addr_of(7, 'h08), 32'hA5A5_0007); m_regs[7][0] = 32'hA5A5_0007;
        wr(addr_of(8, 'h08), 32'h5A5A_0008); m_regs[8][0] = 32'h5A5A_0008;
        rd(12'h1C8, d); check("R2 ctx7 at 0x1C8", d, 32'hA5A5_0007);
        rd(12'h808, d); check("R2 ctx8 at 0x808", d, 32'h5A5A_0008);
        wr(12'h9E8, 32'hCAFE_F00D); m_regs[15][4] = 32'hCAFE_F00D;
        rd(addr_of(15, 'h28), d); check("R2 ctx15 attr", d, 32'hCAFE_F00D);

        // R3 unmapped space
        rd(12'h208, d); check("R3 hole read", d, 0);
        wr(12'h208, 32'hFFFF_FFFF);
        rd(12'h808, d); check("R3 hole write leaves ctx8", d, 32'h5A5A_0008);
        rd(12'hA08, d); check("R3 above last ctx", d, 0);
        wr(addr_of(3, 'h04), 32'h1234_5678);
        rd(addr_of(3, 'h04), d); check("R3 unlisted offset", d, 0);
        wr(addr_of(3, 'h30), 32'h1111_2222);
        rd(addr_of(3, 'h30), d); check("R3 fault addr read-only", d, 0);

        // R2 random register traffic against a model
        for (int it = 0; it < 150; it++) begin
            int c, k;
            logic [31:0] v;
            c = int'($urandom_range(NC - 1));
            k = int'($urandom_range(4));
            v = $urandom;
            wr(addr_of(c, cfg_off(k)), v);
            m_regs[c][k] = v;
            c = int'($urandom_range(NC - 1));
            k = int'($urandom_range(4));
            rd(addr_of(c, cfg_off(k)), d);
            check("R2 random readback", d, m_regs[c][k]);
        end

        // R4 control bits
        wr(addr_of(2, 0), 32'hFFFF_FFFD);
        rd(addr_of(2, 0), d); check("R4 ie/en readback", d, 32'h5);
        check("R4 no flush when bit1 clear", flush_req, 0);
        wr(addr_of(2, 0), 32'h0);
        rd(addr_of(2, 0), d); check("R4 disable", d, 0);

        // R5 flush handshake, R11 no second request
        wr(addr_of(10, 0), 32'h3);
        check("R5 request pulse", flush_req, 64'(1 << 10));
        @(negedge clk);
        check("R5 request one cycle", flush_req, 0);
        rd(addr_of(10, 0), d); check("R5 busy readback", d, 32'h3);
        wr(addr_of(10, 0), 32'h3);
        check("R11 no request while busy", flush_req, 0);
        done_pulse(10);
        rd(addr_of(10, 0), d); check("R6 done clears busy", d, 32'h1);
        check("R6 no timeout after done", flush_timeout, 0);

        // R6 watchdog expiry
        wr(addr_of(4, 0), 32'h2);
        repeat (TO - 1) @(negedge clk);
        check("R6 still waiting", flush_timeout[4], 0);
        @(negedge clk);
        check("R6 timeout set", flush_timeout[4], 1);
        rd(addr_of(4, 0), d); check("R6 busy released", d, 0);
        wr(addr_of(4, 0), 32'h2);
        check("R6 timeout cleared on restart", flush_timeout[4], 0);
        done_pulse(4);
        rd(addr_of(4, 0), d); check("R6 restart done", d, 0);

        // R7 fault capture, R10 interrupt
        wr(addr_of(5, 0), 32'h4);
        fault(5, 5'b11111, 64'h0000_00AB_1234_5678);
        check("R10 irq on enabled fault", irq, 1);
        rd(addr_of(5, 'h20), d); check("R7 status masked", d, 32'h17);
        rd(addr_of(5, 'h30), d); check("R7 addr low", d, 32'h1234_5678);
        rd(addr_of(5, 'h34), d); check("R7 addr high", d, 32'h0000_00AB);

        // R8 first fault kept
        fault(5, 5'b00010, 64'hDEAD_BEEF_0000_0001);
        rd(addr_of(5, 'h20), d); check("R8 status kept", d, 32'h17);
        rd(addr_of(5, 'h30), d); check("R8 addr kept", d, 32'h1234_5678);

        // R9 clearing
        wr(addr_of(5, 'h20), 32'h1);
        rd(addr_of(5, 'h20), d); check("R9 nonzero write ignored", d, 32'h17);
        wr(addr_of(5, 'h20), 32'h0);
        check("R10 irq drops after clear", irq, 0);
        rd(addr_of(5, 'h20), d); check("R9 status cleared", d, 0);
        rd(addr_of(5, 'h30), d); check("R9 addr low cleared", d, 0);
        rd(addr_of(5, 'h34), d); check("R9 addr high cleared", d, 0);
        fault(5, 5'b00100, 64'h0000_0000_0000_4000);
        rd(addr_of(5, 'h30), d); check("R8 new fault after clear", d, 32'h4000);
        wr(addr_of(5, 'h20), 32'h0);

        // R7 ignored flag, R10 enable gating
        fault(12, 5'b01000, 64'h77);
        rd(addr_of(12, 'h20), d); check("R7 unkept flag ignored", d, 0);
        fault(12, 5'b10000, 64'h99);
        check("R10 no irq without enable", irq, 0);
        rd(addr_of(12, 'h20), d); check("R7 multi-hit stored", d, 32'h10);
        wr(addr_of(12, 0), 32'h4);
        check("R10 irq after enable", irq, 1);
        wr(addr_of(12, 'h20), 32'h0);
        check("R10 irq low at end", irq, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule